// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB display panel: horizontal sync, vertical sync, a data-enable strobe marking visible pixels, a pixel strobe, and the current horizontal and vertical raster counts. Each line and each frame pass through four phases in turn: sync pulse, back porch, active region and front porch. Every phase length is programmed as its count minus one.

A programmable divider derives the pixel rate from the source clock. The divider can also be bypassed so that the raster advances on every source cycle. Each of the four timing outputs has its own polarity control. A sticky frame flag is raised at the start of each vertical sync, and software clears it with a clear pulse.

The generator runs only while both the output enable and the frame enable are high. When either one drops, every output returns to its inactive level and the raster restarts from the first sync pixel of the first line.

Top module: `rgb_panel_timing`

## Requirements
- R1: A line is hsw+1 sync pixels, then hbp+1 back-porch pixels, then hact+1 active pixels, then hfp+1 front-porch pixels, where each field holds the count minus one. The raw horizontal sync is high only during the sync pixels.
- R2: A frame follows the same order in lines: vsw+1 sync lines, vbp+1 back-porch lines, vact+1 active lines, vfp+1 front-porch lines. The vertical count advances when the last pixel of a line is passed.
- R3: The raw data enable is high only when the pixel is in the active region of its line and the line is in the active region of the frame.
- R4: inv_hsync_i, inv_vsync_i, inv_den_i and inv_pclk_i each invert only their own output (1 = inverted). This also applies while the generator is stopped.
- R5: For a divider field d greater than 0, the raster advances once every d+1 source cycles. For d = 0 the divider is bypassed and the raster advances on every source cycle.
- R6: The raw pclk_o is high for exactly the source cycles on which the raster advances.
- R7: irq_o is set on the pixel step taken from horizontal count 0 of line 0, which is the first pixel of vertical sync. It stays set until an irq_clr_i pulse. A set and a clear in the same cycle leave the flag set.
- R8: The raster advances only while run_i and frame_en_i are both 1. While either is 0, the raw sync, enable and pixel strobe outputs are 0 and both counts return to 0.
- R9: pix_x_o and line_y_o report the raw raster position, where 0 is the first sync pixel and the first sync line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Output enable |
| frame_en_i | input | 1 | Frame-level enable |
| div_m1_i | input | DW | Pixel divide minus one (0 = bypass) |
| h_sync_m1_i | input | PW | Hsync width minus one |
| h_back_m1_i | input | PW | Horizontal back porch minus one |
| h_act_m1_i | input | AW | Active pixels per line minus one |
| h_front_m1_i | input | PW | Horizontal front porch minus one |
| v_sync_m1_i | input | PW | Vsync width minus one, in lines |
| v_back_m1_i | input | PW | Vertical back porch minus one |
| v_act_m1_i | input | AW | Active lines minus one |
| v_front_m1_i | input | PW | Vertical front porch minus one |
| inv_hsync_i | input | 1 | Invert hsync_o |
| inv_vsync_i | input | 1 | Invert vsync_o |
| inv_den_i | input | 1 | Invert den_o |
| inv_pclk_i | input | 1 | Invert pclk_o |
| irq_clr_i | input | 1 | Clear pulse for the frame flag |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data enable |
| pclk_o | output | 1 | Pixel strobe |
| pix_x_o | output | CW | Horizontal raster count |
| line_y_o | output | CW | Vertical raster count |
| irq_o | output | 1 | Frame flag |

## Verification
A horizontal count that is off by one moves the hsync and data-enable edges and shows up in pix_x_o on the very next pixel step. A vertical count error stays hidden until the next line boundary, and then corrupts vsync, line_y_o and the frame flag together. A divider that slips changes the spacing of pclk_o within one divide period. The bench therefore compares every output against a behavioural raster model on every clock, with several divider settings, both polarities, and enable drops in the middle of a frame.

// File: rtl/rgb_tg_pkg.sv
package rgb_tg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC  = 2'd0,
    PH_BACK  = 2'd1,
    PH_ACT   = 2'd2,
    PH_FRONT = 2'd3
  } phase_e;
endpackage

// File: rtl/rgb_tg_clkdiv.sv
module rgb_tg_clkdiv #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] div_m1_i,
  output logic          tick_o
);
  logic [DW-1:0] cnt_q;
  logic bypass, at_top;

  assign bypass = (div_m1_i == '0);
  assign at_top = (cnt_q >= div_m1_i);
  assign tick_o = en_i & (bypass | at_top);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i)              cnt_q <= '0;
    else if (bypass || at_top)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + DW'(1);
  end

  // R5: a divided strobe never repeats on the next cycle
  p_div_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_m1_i != '0) |=> (!tick_o || div_m1_i == '0));
endmodule

// File: rtl/rgb_tg_axis.sv
module rgb_tg_axis
  import rgb_tg_pkg::*;
#(
  parameter int PW = 8,
  parameter int AW = 11,
  parameter int CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [PW-1:0] sync_m1_i,
  input  logic [PW-1:0] back_m1_i,
  input  logic [AW-1:0] act_m1_i,
  input  logic [PW-1:0] front_m1_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o,
  output phase_e        phase_o
);
  logic [CW-1:0] cnt_q, end_sync, end_back, end_act, last_idx;

  assign end_sync = CW'(sync_m1_i) + CW'(1);
  assign end_back = end_sync + CW'(back_m1_i) + CW'(1);
  assign end_act  = end_back + CW'(act_m1_i) + CW'(1);
  assign last_idx = end_act + CW'(front_m1_i);
  assign last_o   = (cnt_q >= last_idx);
  assign cnt_o    = cnt_q;

  always_comb begin
    if (cnt_q < end_sync)      phase_o = PH_SYNC;
    else if (cnt_q < end_back) phase_o = PH_BACK;
    else if (cnt_q < end_act)  phase_o = PH_ACT;
    else                       phase_o = PH_FRONT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + CW'(1);
  end

  // R1/R2: stepping past the last position returns to the sync phase
  p_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && last_o && !clr_i) |=> (cnt_q == '0 && phase_o == PH_SYNC));
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
  import rgb_tg_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 8,
  parameter int AW = 11,
  localparam int CW = $clog2((1 << AW) + 3 * (1 << PW))
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          frame_en_i,
  input  logic [DW-1:0] div_m1_i,
  input  logic [PW-1:0] h_sync_m1_i,
  input  logic [PW-1:0] h_back_m1_i,
  input  logic [AW-1:0] h_act_m1_i,
  input  logic [PW-1:0] h_front_m1_i,
  input  logic [PW-1:0] v_sync_m1_i,
  input  logic [PW-1:0] v_back_m1_i,
  input  logic [AW-1:0] v_act_m1_i,
  input  logic [PW-1:0] v_front_m1_i,
  input  logic          inv_hsync_i,
  input  logic          inv_vsync_i,
  input  logic          inv_den_i,
  input  logic          inv_pclk_i,
  input  logic          irq_clr_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          den_o,
  output logic          pclk_o,
  output logic [CW-1:0] pix_x_o,
  output logic [CW-1:0] line_y_o,
  output logic          irq_o
);
  logic en, tick, h_last, v_last, v_step, irq_set, irq_q;
  logic hs_raw, vs_raw, de_raw;
  logic [CW-1:0] h_cnt, v_cnt;
  phase_e h_ph, v_ph;

  assign en     = run_i & frame_en_i;
  assign v_step = tick & h_last;

  rgb_tg_clkdiv #(.DW(DW)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .div_m1_i(div_m1_i), .tick_o(tick)
  );

  rgb_tg_axis #(.PW(PW), .AW(AW), .CW(CW)) u_h (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en), .step_i(tick),
    .sync_m1_i(h_sync_m1_i), .back_m1_i(h_back_m1_i),
    .act_m1_i(h_act_m1_i), .front_m1_i(h_front_m1_i),
    .cnt_o(h_cnt), .last_o(h_last), .phase_o(h_ph)
  );

  rgb_tg_axis #(.PW(PW), .AW(AW), .CW(CW)) u_v (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!en), .step_i(v_step),
    .sync_m1_i(v_sync_m1_i), .back_m1_i(v_back_m1_i),
    .act_m1_i(v_act_m1_i), .front_m1_i(v_front_m1_i),
    .cnt_o(v_cnt), .last_o(v_last), .phase_o(v_ph)
  );

  assign hs_raw = en & (h_ph == PH_SYNC);
  assign vs_raw = en & (v_ph == PH_SYNC);
  assign de_raw = en & (h_ph == PH_ACT) & (v_ph == PH_ACT);

  // frame flag: first pixel step of vertical sync
  assign irq_set = tick & (h_cnt == '0) & (v_cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  assign hsync_o  = hs_raw ^ inv_hsync_i;
  assign vsync_o  = vs_raw ^ inv_vsync_i;
  assign den_o    = de_raw ^ inv_den_i;
  assign pclk_o   = tick   ^ inv_pclk_i;
  assign pix_x_o  = h_cnt;
  assign line_y_o = v_cnt;
  assign irq_o    = irq_q;

  p_den_excl_sync_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_raw |-> (!hs_raw && !vs_raw));

  p_irq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_clr_i && !irq_set) |=> !irq_q);

  p_stop_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (h_cnt == '0 && v_cnt == '0));

  p_frame_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && v_step && v_last) |=> (v_cnt == '0 || !en));
endmodule

// File: tb/tb_rgb_panel_timing.sv
module tb_rgb_panel_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 0, fen = 0, clr = 0;
  logic [7:0] div = 0;
  logic [7:0] hsw = 1, hbp = 0, hfp = 1, vsw = 0, vbp = 1, vfp = 0;
  logic [10:0] hact = 3, vact = 2;
  logic ih = 0, iv = 0, id = 0, ip = 0;
  logic hs, vs, de, pc, irq;
  logic [11:0] px, ly;

  int vectors = 0, errors = 0, cycles = 0;
  int dc = 0, hc = 0, vc = 0;
  bit m_irq = 0;

  always #4 clk = ~clk;

  rgb_panel_timing dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .frame_en_i(fen), .div_m1_i(div),
    .h_sync_m1_i(hsw), .h_back_m1_i(hbp), .h_act_m1_i(hact), .h_front_m1_i(hfp),
    .v_sync_m1_i(vsw), .v_back_m1_i(vbp), .v_act_m1_i(vact), .v_front_m1_i(vfp),
    .inv_hsync_i(ih), .inv_vsync_i(iv), .inv_den_i(id), .inv_pclk_i(ip),
    .irq_clr_i(clr), .hsync_o(hs), .vsync_o(vs), .den_o(de), .pclk_o(pc),
    .pix_x_o(px), .line_y_o(ly), .irq_o(irq)
  );

  function automatic bit m_en(); return run && fen; endfunction
  function automatic bit m_tick();
    return m_en() && (div == 0 || dc >= int'(div));
  endfunction
  function automatic int htot(); return hsw + hbp + hact + hfp + 4; endfunction
  function automatic int vtot(); return vsw + vbp + vact + vfp + 4; endfunction

  // behavioural raster model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc = 0; hc = 0; vc = 0; m_irq = 0;
    end else begin
      bit t, s;
      t = m_tick();
      s = t && hc == 0 && vc == 0;
      if (s) m_irq = 1; else if (clr) m_irq = 0;
      if (!m_en()) begin
        dc = 0; hc = 0; vc = 0;
      end else begin
        if (t) dc = 0; else dc++;
        if (t) begin
          hc++;
          if (hc >= htot()) begin
            hc = 0; vc++;
            if (vc >= vtot()) vc = 0;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rst_n) begin
      bit e_hs, e_vs, e_de, e_pc;
      bit hact_ph, vact_ph;
      hact_ph = hc >= hsw + hbp + 2 && hc < hsw + hbp + hact + 3;
      vact_ph = vc >= vsw + vbp + 2 && vc < vsw + vbp + vact + 3;
      e_hs = (m_en() && hc < hsw + 1) ^ ih;
      e_vs = (m_en() && vc < vsw + 1) ^ iv;
      e_de = (m_en() && hact_ph && vact_ph) ^ id;
      e_pc = m_tick() ^ ip;
      vectors++;
      chk(hs == e_hs, "R1 hsync", hs, e_hs);
      chk(vs == e_vs, "R2 vsync", vs, e_vs);
      chk(de == e_de, "R3 den", de, e_de);
      chk(pc == e_pc, "R6 pclk", pc, e_pc);
      chk(int'(px) == hc, "R9 pix_x", px, hc);
      chk(int'(ly) == vc, "R9 line_y", ly, vc);
      chk(irq == m_irq, "R7 irq", irq, m_irq);
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sample();
    @(posedge clk); #3;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1;
    sample();
    vectors++;
    chk(hs == 0 && vs == 0 && de == 0 && pc == 0 && irq == 0, "R8 reset idle", {hs,vs,de,pc,irq}, 0);
    // bypass divider
    @(negedge clk); run = 1; fen = 1;
    wait_cyc(150);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    wait_cyc(80);
    // stop mid-frame via frame enable
    @(negedge clk); fen = 0;
    sample();
    vectors++;
    chk(px == 0 && ly == 0 && de == 0 && hs == 0, "R8 stop restart", {px, ly}, 0);
    // divided rate, R5
    @(negedge clk); div = 2; fen = 1;
    begin
      int n = 0;
      for (int i = 0; i < 30; i++) begin
        sample();
        if (pc) n++;
      end
      vectors++;
      chk(n == 10, "R5 divide by 3", n, 10);
    end
    wait_cyc(300);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    wait_cyc(200);
    // inversion while stopped, R4
    @(negedge clk); run = 0; ih = 1; iv = 1; id = 1; ip = 1;
    sample();
    vectors++;
    chk(hs && vs && de && pc, "R4 inverted idle", {hs,vs,de,pc}, 15);
    @(negedge clk); ih = 0; ip = 0;
    sample();
    vectors++;
    chk(!hs && vs && de && !pc, "R4 independent bits", {hs,vs,de,pc}, 6);
    // new geometry, divide by 2, inverted sync
    @(negedge clk); ih = 1; ip = 1; id = 0; hsw = 0; hbp = 2; hact = 5; hfp = 0;
    vsw = 1; vbp = 0; vact = 3; vfp = 1; div = 1; run = 1;
    wait_cyc(500);
    // clear held while flag sets: set wins
    @(negedge clk); clr = 1; wait_cyc(300); @(negedge clk); clr = 0;
    wait_cyc(40);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule